// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the protocol engine of a small two-wire serial memory. It watches already-synchronized samples of the clock and data lines, frames each transfer between start and stop conditions, and checks a fixed 4-bit device code. After a match it either takes a 7-bit word address and up to a page of write data, or streams bytes out of a 128-byte array. The array itself sits outside the block. The block drives its write port and its combinational read port. The data line leaves as a single pull-low enable, because the bus is open-drain.

Write data is collected in an 8-entry page latch and is not stored anywhere until a stop condition arrives. Two conditions must both hold at that stop: the write-enable level is high, and at least one complete data byte was received. When they do, the block enters a self-timed busy interval that lasts a parameterized number of clock cycles. It copies the latched bytes into the array during the first cycles of that interval. While busy it acknowledges no device address, so a master can poll for completion. One internal pointer serves current-address reads. It rests on the last written location after a write, and one past the last read location after a read.

Top module: `eeprom_2w_slave`

## Requirements
- R1: A start condition (data falls while clock is high) begins a transfer and a stop condition (data rises while clock is high) ends it; bytes clocked before any start receive no acknowledge.
- R2: The first byte after a start is acknowledged only when its four upper bits are 1010; its next three bits are ignored, and its lowest bit selects a read (1) or a write (0).
- R3: Data is sampled on rising clock edges, and the pull-low enable changes only while the clock is low (after a falling edge).
- R4: Write data reaches the array only after a stop condition. A repeated start before the stop discards the latched bytes and starts no busy interval.
- R5: In a write, the low 3 bits of the address step after each data byte and wrap within the 8-byte page, while the upper 4 bits stay fixed; a ninth byte overwrites the first.
- R6: After a write whose last byte went to address n, a current-address read returns address n. After a read of address n, the next current-address read returns n+1.
- R7: A read continues through consecutive addresses for as long as the master acknowledges, stepping all 7 address bits and rolling from 127 to 0; a master not-acknowledge ends the transmission.
- R8: If the write-enable input is low at the stop condition, no busy interval starts and the array is unchanged; lowering write-enable during a busy interval does not stop that commit.
- R9: The busy flag stays high for exactly WR_CYCLES clock cycles, and during that time device addresses are not acknowledged and the data line is never pulled low.
- R10: A start followed directly by a stop while a command is being entered cancels it: no busy interval starts and the array is unchanged.
- R11: Array writes occur only while busy, at most one entry per cycle, and every latched entry of the page is written once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock sample |
| sda_i | input | 1 | Synchronized serial data sample (resolved bus level) |
| wr_en_i | input | 1 | Write-enable level, sampled at the stop condition |
| sda_pull_o | output | 1 | Pull the data line low when high |
| mem_we_o | output | 1 | Array write strobe |
| mem_waddr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| mem_raddr_o | output | ADDR_W | Array read address (current pointer) |
| mem_rdata_i | input | DATA_W | Array read data for mem_raddr_o, combinational |
| busy_o | output | 1 | Self-timed write interval in progress |

## Verification
The assertions check the following on every cycle: array writes appear only inside a busy interval and stay within one page; a busy interval begins only on a stop with write-enable high and lasts exactly WR_CYCLES; the data line stays released while busy; and the pull-low enable never moves while the clock is high. Other behaviour only shows up across whole bus transactions in the bench scenarios. That covers the device-code filter, page wrap-around and overwrite, where the pointer rests after writes and reads, sequential roll-over from 127 to 0, repeated-start discard and start-stop cancel, and acknowledge polling.

// File: rtl/e2w_pkg.sv
package e2w_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } e2w_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;

endpackage

// File: rtl/e2w_bus_cond.sv
module e2w_bus_cond
  import e2w_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // data edges with clock held high are frame markers
  assign ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
  assign ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
  assign ev_o.rise  = scl_i & ~scl_q;
  assign ev_o.fall  = ~scl_i & scl_q;

endmodule

// File: rtl/e2w_proto.sv
module e2w_proto
  import e2w_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter int          DATA_W   = 8,
  parameter int          PAGE_W   = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  bus_ev_t                  ev_i,
  input  logic                     sda_i,
  input  logic                     busy_i,
  input  logic [DATA_W-1:0]        rdata_i,
  output logic [ADDR_W-1:0]        raddr_o,
  output logic                     pull_o,
  output logic                     pg_we_o,
  output logic [PAGE_W-1:0]        pg_idx_o,
  output logic [ADDR_W-PAGE_W-1:0] pg_base_o,
  output logic [DATA_W-1:0]        pg_data_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);

  e2w_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [DATA_W-1:0]   sh_q;
  logic [DATA_W-1:0]   tx_q;
  logic [ADDR_W-1:0]   ptr_q;
  logic [PAGE_W-1:0]   col_q;
  logic                rw_q;
  logic                ack_q;

  logic byte_done, code_ok;

  assign byte_done = (cnt_q == BYTE_END);
  assign code_ok   = (sh_q[DATA_W-1 -: 4] == DEV_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '1;
      ptr_q   <= '0;
      col_q   <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else if (ev_i.start) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else if (ev_i.stop) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (ev_i.rise) begin
            sh_q  <= {sh_q[DATA_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (ev_i.fall && byte_done) begin
            cnt_q <= '0;
            case (state_q)
              ST_DEV: begin
                if (code_ok && !busy_i) begin
                  ack_q   <= 1'b1;
                  rw_q    <= sh_q[0];
                  state_q <= ST_DEV_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_WADR: begin
                ptr_q   <= sh_q[ADDR_W-1:0];
                col_q   <= sh_q[PAGE_W-1:0];
                ack_q   <= 1'b1;
                state_q <= ST_WADR_ACK;
              end
              default: begin
                // pointer follows the last byte latched; column wraps in page
                ptr_q   <= {ptr_q[ADDR_W-1:PAGE_W], col_q};
                col_q   <= col_q + 1'b1;
                ack_q   <= 1'b1;
                state_q <= ST_WDAT_ACK;
              end
            endcase
          end
        end
        ST_DEV_ACK: begin
          if (ev_i.fall) begin
            ack_q <= 1'b0;
            if (rw_q) begin
              tx_q    <= rdata_i;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RDAT;
            end else begin
              state_q <= ST_WADR;
            end
          end
        end
        ST_WADR_ACK, ST_WDAT_ACK: begin
          if (ev_i.fall) begin
            ack_q   <= 1'b0;
            state_q <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (ev_i.rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (ev_i.fall) begin
            if (byte_done) begin
              cnt_q   <= '0;
              state_q <= ST_RACK;
            end else begin
              tx_q <= {tx_q[DATA_W-2:0], 1'b1};
            end
          end
        end
        ST_RACK: begin
          if (ev_i.rise && sda_i) begin
            state_q <= ST_IDLE;
          end else if (ev_i.fall) begin
            tx_q    <= rdata_i;
            ptr_q   <= ptr_q + 1'b1;
            state_q <= ST_RDAT;
          end
        end
        default: ;
      endcase
    end
  end

  assign pull_o    = (state_q == ST_RDAT) ? ~tx_q[DATA_W-1] : ack_q;
  assign raddr_o   = ptr_q;
  assign pg_we_o   = (state_q == ST_WDAT) && ev_i.fall && byte_done && !ev_i.start && !ev_i.stop;
  assign pg_idx_o  = col_q;
  assign pg_base_o = ptr_q[ADDR_W-1:PAGE_W];
  assign pg_data_o = sh_q;

endmodule

// File: rtl/e2w_page_commit.sv
module e2w_page_commit #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 200
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     wr_en_i,
  input  logic                     pg_we_i,
  input  logic [PAGE_W-1:0]        pg_idx_i,
  input  logic [ADDR_W-PAGE_W-1:0] pg_base_i,
  input  logic [DATA_W-1:0]        pg_data_i,
  output logic                     busy_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_waddr_o,
  output logic [DATA_W-1:0]        mem_wdata_o
);

  localparam int PAGE_N = 1 << PAGE_W;
  localparam int TW     = (WR_CYCLES > PAGE_N) ? $clog2(WR_CYCLES) : PAGE_W + 1;
  localparam logic [TW-1:0] T_LAST = TW'(WR_CYCLES - 1);
  localparam logic [TW-1:0] T_WIN  = TW'(PAGE_N);

  logic [DATA_W-1:0]        buf_q [PAGE_N];
  logic [PAGE_N-1:0]        mask_q;
  logic [ADDR_W-PAGE_W-1:0] base_q;
  logic [TW-1:0]            tmr_q;
  logic                     busy_q;

  logic commit, busy_end, drop;
  logic [PAGE_W-1:0] slot;

  assign commit   = !busy_q && stop_i && (|mask_q) && wr_en_i;
  assign busy_end = busy_q && (tmr_q == T_LAST);
  assign drop     = !busy_q && (start_i || stop_i) && !commit;
  assign slot     = tmr_q[PAGE_W-1:0];

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g]  <= '0;
        mask_q[g] <= 1'b0;
      end else if (pg_we_i && pg_idx_i == PAGE_W'(g)) begin
        buf_q[g]  <= pg_data_i;
        mask_q[g] <= 1'b1;
      end else if (drop || busy_end) begin
        mask_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (pg_we_i) begin
      base_q <= pg_base_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else if (commit) begin
      busy_q <= 1'b1;
      tmr_q  <= '0;
    end else if (busy_q) begin
      if (busy_end) busy_q <= 1'b0;
      else          tmr_q  <= tmr_q + 1'b1;
    end
  end

  // drain one page slot per cycle at the head of the busy interval
  assign mem_we_o    = busy_q && (tmr_q < T_WIN) && mask_q[slot];
  assign mem_waddr_o = {base_q, slot};
  assign mem_wdata_o = buf_q[slot];
  assign busy_o      = busy_q;

endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
  parameter int         ADDR_W    = 7,
  parameter int         DATA_W    = 8,
  parameter int         PAGE_W    = 3,
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter int         WR_CYCLES = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wr_en_i,
  output logic              sda_pull_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o
);

  import e2w_pkg::*;

  bus_ev_t                  ev;
  logic                     start_w, stop_w;
  logic                     pg_we;
  logic [PAGE_W-1:0]        pg_idx;
  logic [ADDR_W-PAGE_W-1:0] pg_base;
  logic [DATA_W-1:0]        pg_data;

  assign start_w = ev.start;
  assign stop_w  = ev.stop;

  e2w_bus_cond u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (ev)
  );

  e2w_proto #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W),
    .DEV_CODE(DEV_CODE)
  ) u_proto (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .sda_i    (sda_i),
    .busy_i   (busy_o),
    .rdata_i  (mem_rdata_i),
    .raddr_o  (mem_raddr_o),
    .pull_o   (sda_pull_o),
    .pg_we_o  (pg_we),
    .pg_idx_o (pg_idx),
    .pg_base_o(pg_base),
    .pg_data_o(pg_data)
  );

  e2w_page_commit #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_W   (PAGE_W),
    .WR_CYCLES(WR_CYCLES)
  ) u_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .wr_en_i    (wr_en_i),
    .pg_we_i    (pg_we),
    .pg_idx_i   (pg_idx),
    .pg_base_i  (pg_base),
    .pg_data_i  (pg_data),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_waddr_o(mem_waddr_o),
    .mem_wdata_o(mem_wdata_o)
  );

endmodule

// File: rtl/eeprom_2w_slave_chk.sv
module eeprom_2w_slave_chk #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              wr_en_i,
  input logic              stop_i,
  input logic              busy_o,
  input logic              sda_pull_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_waddr_o
);

  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  // R11
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(stop_i) && $past(wr_en_i)));

  // R9
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_pull_o);

  // R9
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == WR_CYCLES));

  // R5
  page_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_waddr_o[ADDR_W-1:PAGE_W] == $past(mem_waddr_o[ADDR_W-1:PAGE_W])));

  // R3
  pull_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_i);

endmodule

bind eeprom_2w_slave eeprom_2w_slave_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_W   (PAGE_W),
  .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .wr_en_i    (wr_en_i),
  .stop_i     (stop_w),
  .busy_o     (busy_o),
  .sda_pull_o (sda_pull_o),
  .mem_we_o   (mem_we_o),
  .mem_waddr_o(mem_waddr_o)
);

// File: tb/tb_eeprom_2w_slave.sv
module tb_eeprom_2w_slave;

  localparam int AW    = 7;
  localparam int DW    = 8;
  localparam int WRC   = 200;
  localparam int DEPTH = 1 << AW;
  localparam int H     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wen = 1'b1;

  logic          pull, mem_we, busy;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata;
  logic          sda_line;

  logic [7:0] mem   [DEPTH];
  logic [7:0] ref_m [DEPTH];
  logic [7:0] wbuf  [16];
  logic [6:0] ref_ptr;
  bit         ptr_ok;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;
  int         we_cnt = 0;
  int         run = 0;
  int         last_len = 0;

  always #10ns clk = ~clk;

  assign sda_line = sda_m & ~pull;
  assign rdata    = mem[raddr];

  eeprom_2w_slave #(.WR_CYCLES(WRC)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .wr_en_i    (wen),
    .sda_pull_o (pull),
    .mem_we_o   (mem_we),
    .mem_waddr_o(waddr),
    .mem_wdata_o(wdata),
    .mem_raddr_o(raddr),
    .mem_rdata_i(rdata),
    .busy_o     (busy)
  );

  // external array model
  always @(posedge clk) if (mem_we) mem[waddr] <= wdata;

  always @(negedge clk) begin
    if (mem_we) we_cnt++;
    if (busy) run++;
    else if (run != 0) begin last_len = run; run = 0; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    sda_m = b; wt(H);
    scl_m = 1'b1; wt(H);
    s = sda_line;
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(~mack, s);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 4 * WRC) begin wt(1); g++; end
    wt(2);
  endtask

  task automatic page_write(input logic [6:0] a, input int n, input logic wl, input bit wait_done);
    logic       ack;
    logic [7:0] pend [8];
    bit         pv [8];
    logic [2:0] idx;
    logic [6:0] first;
    foreach (pv[k]) pv[k] = 1'b0;
    bus_start();
    send_byte(8'hA0, ack);      chk("R2 write device ack", ack, 1);
    send_byte({1'b0, a}, ack);  chk("R2 word address ack", ack, 1);
    idx = a[2:0];
    for (int i = 0; i < n; i++) begin
      idx = 3'(a[2:0] + i);
      send_byte(wbuf[i], ack);  chk("R5 data ack", ack, 1);
      pend[idx] = wbuf[i];
      pv[idx]   = 1'b1;
    end
    ref_ptr = (n > 0) ? {a[6:3], idx} : a;
    ptr_ok  = 1'b1;
    first   = a;
    if (n > 0) chk("R4 array untouched before stop", mem[first], ref_m[first]);
    wen = wl;
    bus_stop();
    if (wl && n > 0) begin
      chk("R4 busy after stop", busy, 1);
      for (int k = 0; k < 8; k++) if (pv[k]) ref_m[{a[6:3], 3'(k)}] = pend[k];
    end else begin
      chk("R8 no busy without commit", busy, 0);
    end
    if (wait_done) wait_idle();
  endtask

  task automatic rand_read(input logic [6:0] a, input int n);
    logic       ack;
    logic [7:0] d;
    logic [6:0] p;
    bus_start();
    send_byte(8'hA0, ack);      chk("R2 dummy write ack", ack, 1);
    send_byte({1'b0, a}, ack);  chk("R2 read address ack", ack, 1);
    bus_start();
    send_byte(8'hA1, ack);      chk("R2 read device ack", ack, 1);
    p = a;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk("R7 R3 sequential read data", d, ref_m[p]);
      p = p + 1'b1;
    end
    bus_stop();
    ref_ptr = p;
    ptr_ok  = 1'b1;
  endtask

  task automatic cur_read(input int n);
    logic       ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA1, ack);      chk("R2 current read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk("R6 current address data", d, ref_m[ref_ptr]);
      ref_ptr = ref_ptr + 1'b1;
    end
    bus_stop();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    int         polls;
    int         we0;
    void'($urandom(32'h2e0e));
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'hFF; ref_m[i] = 8'hFF; end
    ref_ptr = '0;
    ptr_ok  = 1'b0;

    wt(5);
    chk("R3 reset pull released", pull, 0);
    chk("R9 reset not busy", busy, 0);
    chk("R11 reset no write", mem_we, 0);
    rst_n = 1'b1;
    wt(5);

    // R1: byte without a preceding start
    scl_m = 1'b0; wt(H);
    send_byte(8'hA0, ack);
    chk("R1 no ack before start", ack, 0);
    bus_stop();

    // R2: wrong code, then ignored middle bits
    bus_start();
    send_byte(8'hB0, ack); chk("R2 wrong code nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hAE, ack); chk("R2 middle bits ignored", ack, 1);
    bus_stop();
    chk("R2 no busy on address only", busy, 0);

    // R5 R11 R9: ten bytes into page 0x08..0x0F from column 5
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h30 + i);
    we0 = we_cnt;
    page_write(7'h0D, 10, 1'b1, 1'b1);
    chk("R11 one write per page entry", we_cnt - we0, 8);
    chk("R9 busy length", last_len, WRC);
    chk("R5 overwrite at 0x0D", ref_m[7'h0D], 8'h38);
    cur_read(1);
    cur_read(1);
    rand_read(7'h08, 8);

    // R9: acknowledge polling during busy
    wbuf[0] = 8'h5A;
    page_write(7'h20, 1, 1'b1, 1'b0);
    polls = 0;
    do begin
      bus_start();
      send_byte(8'hA0, ack);
      bus_stop();
      if (!ack) polls++;
    end while (!ack && polls < 50);
    chk("R9 nack while busy", polls > 0, 1);
    chk("R9 ack after busy", ack, 1);
    rand_read(7'h20, 1);

    // R7: roll over from 127 to 0
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    page_write(7'h7E, 2, 1'b1, 1'b1);
    wbuf[0] = 8'hD0;
    page_write(7'h00, 1, 1'b1, 1'b1);
    rand_read(7'h7E, 4);
    cur_read(2);

    // R8: write-enable low at stop, then dropped during busy
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    page_write(7'h30, 2, 1'b0, 1'b1);
    wen = 1'b1;
    chk("R8 blocked array value", mem[7'h30], 8'hFF);
    wbuf[0] = 8'h77;
    page_write(7'h31, 1, 1'b1, 1'b0);
    wen = 1'b0;
    wait_idle();
    wen = 1'b1;
    chk("R8 commit survives wen drop", mem[7'h31], 8'h77);
    rand_read(7'h30, 2);

    // R10: start then stop cancels a pending write
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h40, ack);
    send_byte(8'h55, ack);
    bus_start();
    bus_stop();
    chk("R10 cancel no busy", busy, 0);
    chk("R10 cancel array value", mem[7'h40], 8'hFF);
    ptr_ok = 1'b0;

    // R4: repeated start discards latched data
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h50, ack);
    send_byte(8'h12, ack);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R4 discarded data not read", d, 8'hFF);
    chk("R4 no busy after repeated start", busy, 0);
    chk("R4 array unchanged", mem[7'h50], 8'hFF);
    ptr_ok = 1'b0;

    // constrained random traffic
    for (int it = 0; it < 24; it++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) begin
        int n;
        n = 1 + int'($urandom % 11);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        page_write(7'($urandom), n, ($urandom % 4) != 0, 1'b1);
        wen = 1'b1;
      end else if (op == 1 || !ptr_ok) begin
        rand_read(7'($urandom), 1 + int'($urandom % 4));
      end else begin
        cur_read(1 + int'($urandom % 3));
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule